// File: doc/BRIEF.md
# Stepwise Non-Restoring Divider

This block carries out an unsigned 32-by-16 non-restoring division one quotient bit at a time. The division does not run on its own. Each pulse on the step input advances it by exactly one bit. The partial remainder, the shifting dividend, the divisor and a step counter are all kept between pulses, so a controller can interleave steps with any number of idle cycles.

A step counter that holds all ones marks the unit as idle. A step that arrives while the unit is idle captures the operands and also performs the first bit. Sixteen steps complete a division. When the counter runs past zero it falls back to the idle value, and a one-cycle done pulse follows. A cancel input stands for any other operation being issued. It returns the unit to idle, so the next step begins a fresh division.

The low half of the shifting dividend register is shown as the running quotient. The sign of the partial remainder is shown as the AQ flag. No final remainder correction is made, and division by zero is not trapped.

Top module: `step_divider`

## Requirements
- R1: After reset the quotient output is 0, AQ is 0, done is 0, and the unit is idle, so the first step captures operands.
- R2: A step while idle captures the dividend as {dvd_hi_i, dvd_lo_i}, captures the divisor from dvs_i, and starts from a partial remainder of zero.
- R3: On the second through sixteenth steps of a division, the operand inputs are ignored.
- R4: On each step, AQ becomes bit 31 of the 32-bit partial remainder as it was before that step. AQ is visible one cycle after the step.
- R5: On each step the new partial remainder is twice the old one, plus bit 15 of the shifting dividend, plus the divisor when the new AQ is 1 or minus the divisor when it is 0. The result wraps modulo 2^32.
- R6: On each step the dividend register shifts left by one. Its new bit 0 is 1 exactly when bit 31 of the new partial remainder is 0. One cycle after the step, quot_o shows bits 15:0 of the shifted register.
- R7: done_o is 1 for exactly one cycle, in the cycle after the sixteenth step. The unit is idle again after that step, so a step in the very next cycle starts a new division.
- R8: In cycles without a step, quot_o and aq_o hold their values and all division state is kept.
- R9: cancel_i returns the unit to idle without changing quot_o or aq_o. If cancel_i and step_i are both high, the cancel wins and the step is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Perform one division step |
| cancel_i | input | 1 | Abandon any division in progress |
| dvd_hi_i | input | 16 | Upper dividend word, sampled on the first step only |
| dvd_lo_i | input | 16 | Lower dividend word, sampled on the first step only |
| dvs_i | input | 16 | Divisor, sampled on the first step only |
| quot_o | output | 16 | Running quotient (low half of the shifting dividend) |
| aq_o | output | 1 | Partial remainder sign taken at the latest step |
| done_o | output | 1 | One-cycle pulse after the sixteenth step |

## Verification
The bench changes the operand inputs to unrelated values after the first step. A divider that re-sampled operands on later steps would therefore drift from the reference quotient. Idle gaps of varying length are placed between steps. A design that advanced the division, or let quot_o or aq_o move, without a step would be caught in those gaps. Divisions are started in the cycle right after done. A cancel is issued in the middle of a division, and another is issued in the same cycle as a step. A counter that missed its return to idle, a done pulse that was early or too long, or a cancel that lost priority to the step would each make the next division start from the wrong operands or at the wrong bit.

// File: rtl/step_divider.sv
module step_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         cancel_i,
  input  logic [W-1:0] dvd_hi_i,
  input  logic [W-1:0] dvd_lo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quot_o,
  output logic         aq_o,
  output logic         done_o
);
  localparam int AW = 2 * W;
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] IDLE = '1;
  localparam logic [CW-1:0] FIRST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic [AW-1:0] acc, dvd;
  logic [W-1:0]  dvs;

  logic          idle, go;
  logic [AW-1:0] acc_cur, dvd_cur, dvs_ext, acc_nxt, dvd_nxt;
  logic [CW-1:0] cnt_cur;
  logic          aq_nxt;

  assign idle    = (cnt == IDLE);
  assign go      = step_i && !cancel_i;
  assign acc_cur = idle ? '0 : acc;
  assign dvd_cur = idle ? {dvd_hi_i, dvd_lo_i} : dvd;
  assign dvs_ext = {{W{1'b0}}, idle ? dvs_i : dvs};
  assign cnt_cur = idle ? FIRST : cnt;
  assign aq_nxt  = acc_cur[AW-1];
  assign acc_nxt = aq_nxt ? {acc_cur[AW-2:0], dvd_cur[W-1]} + dvs_ext
                          : {acc_cur[AW-2:0], dvd_cur[W-1]} - dvs_ext;
  assign dvd_nxt = {dvd_cur[AW-2:0], ~acc_nxt[AW-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= IDLE;
      acc    <= '0;
      dvd    <= '0;
      dvs    <= '0;
      quot_o <= '0;
      aq_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= go && (cnt_cur == '0);
      if (cancel_i) begin
        cnt <= IDLE;
      end else if (step_i) begin
        cnt    <= cnt_cur - 1'b1;
        acc    <= acc_nxt;
        dvd    <= dvd_nxt;
        if (idle) dvs <= dvs_i;
        quot_o <= dvd_nxt[W-1:0];
        aq_o   <= aq_nxt;
      end
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> cnt == IDLE);

  p_first_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && idle) |=> (cnt == FIRST - 1'b1) && (dvs == $past(dvs_i)));

  p_divisor_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !cancel_i) |=> $stable(dvs));

  p_aq_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !idle) |=> aq_o == $past(acc[AW-1]));

  p_quot_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> quot_o == dvd[W-1:0]);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cnt == IDLE || $past(cancel_i) || $past(step_i)) && !$past(done_o));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(quot_o) && $stable(aq_o) && $stable(acc) && $stable(dvd));

  p_cancel_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_i |=> (cnt == IDLE) && !done_o);
endmodule

// File: tb/sim_step_divider.sv
module sim_step_divider;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_i = 1'b0, cancel_i = 1'b0;
  logic [15:0] dvd_hi_i = '0, dvd_lo_i = '0, dvs_i = '0;
  logic [15:0] quot_o;
  logic aq_o, done_o;

  always #4 clk = ~clk;

  step_divider u0 (.clk(clk), .rst_n(rst_n), .step_i(step_i), .cancel_i(cancel_i),
    .dvd_hi_i(dvd_hi_i), .dvd_lo_i(dvd_lo_i), .dvs_i(dvs_i),
    .quot_o(quot_o), .aq_o(aq_o), .done_o(done_o));

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;
  string phase = "R1";

  // behavioural reference
  int m_left = -1;
  bit [31:0] m_acc, m_dvd;
  bit [15:0] m_dvs, e_quot;
  bit e_aq, e_done;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_left = -1; m_acc = 0; m_dvd = 0; m_dvs = 0;
      e_quot = 0; e_aq = 0; e_done = 0;
    end else begin
      e_done = 0;
      if (cancel_i) m_left = -1;
      else if (step_i) begin
        bit s;
        if (m_left < 0) begin
          m_left = 16; m_acc = 0; m_dvd = {dvd_hi_i, dvd_lo_i}; m_dvs = dvs_i;
        end
        s = m_acc[31];
        e_aq = s;
        m_acc = (m_acc << 1) + 32'(m_dvd[15]);
        if (s) m_acc = m_acc + 32'(m_dvs); else m_acc = m_acc - 32'(m_dvs);
        m_dvd = (m_dvd << 1) | 32'(!m_acc[31]);
        e_quot = m_dvd[15:0];
        m_left--;
        if (m_left == 0) begin m_left = -1; e_done = 1; end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk({phase, " R6 quotient"}, 32'(quot_o), 32'(e_quot));
    chk({phase, " R4 aq"}, 32'(aq_o), 32'(e_aq));
    chk({phase, " R7 done"}, 32'(done_o), 32'(e_done));
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step(bit cancel = 0);
    step_i = 1; cancel_i = cancel;
    @(negedge clk);
    step_i = 0; cancel_i = 0;
    dvd_hi_i = $urandom; dvd_lo_i = $urandom; dvs_i = $urandom;  // R3: junk after sampling
  endtask

  task automatic divide(logic [31:0] dd, logic [15:0] dv, int gap, int nsteps = 16);
    dvd_hi_i = dd[31:16]; dvd_lo_i = dd[15:0]; dvs_i = dv;
    for (int i = 0; i < nsteps; i++) begin
      step();
      if (gap > 0) idle(gap);
    end
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1 quot", 32'(quot_o), 0);
    chk("R1 aq", 32'(aq_o), 0);
    chk("R1 done", 32'(done_o), 0);
    phase = "R2 R5";
    divide(32'd1000, 16'd7, 0);
    phase = "R7 back-to-back";
    divide(32'hFFFF_FFFF, 16'h0001, 0);
    divide(32'h0001_0000, 16'hFFFF, 0);
    phase = "R8 gaps";
    divide(32'h1234_5678, 16'h00AB, 2);
    divide(32'h8000_0001, 16'h8000, 1);
    phase = "R3 operand junk";
    divide(32'h7FFF_0000, 16'h0003, 0);
    phase = "R9 cancel mid";
    divide(32'h0BAD_CAFE, 16'h0321, 0, 7);
    dvd_hi_i = 16'h0000; dvd_lo_i = 16'h0064; dvs_i = 16'h0005;
    cancel_i = 1; @(negedge clk); cancel_i = 0;
    chk("R9 done after cancel", 32'(done_o), 0);
    divide(32'h0000_0064, 16'h0005, 0);
    phase = "R9 cancel with step";
    divide(32'h0000_4444, 16'h0011, 0, 5);
    step(1);
    divide(32'h0000_0009, 16'h0003, 0);
    phase = "R5 random";
    for (int k = 0; k < 20; k++)
      divide({$urandom}, 16'($urandom), k % 3);
    idle(2);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule